// File: doc/BRIEF.md
# Serial Frame Clock-Count Guard

This block watches a three-wire serial slave while it receives an instruction. From the cycle in which the decoder reports a start bit until chip select drops, it counts serial clock rise strobes. When chip select falls it compares that count with the exact frame length that the decoded instruction should have. The length depends on the instruction class, the word organization and the address width. For a programming instruction (write, erase, write-all, erase-all) it emits a single-cycle commit pulse when the count is exact, and a single-cycle abort pulse otherwise. A frame shifted by a clock glitch, or cut short, therefore never reaches the memory array.

The decoder and the array controller sit around this guard. The decoder supplies the class code and keeps it steady until chip select falls. The array controller performs the pending program operation only on commit and drops it on abort. Read, enable and disable frames pass through the guard with no pulse at all. Neither pulse is needed for them, since they never change the array.

The expected length is 1 start bit, plus 2 opcode bits, plus the address field, plus a data field for write and write-all. The address field is `addr_w_i` bits with 16-bit organization and one bit longer with 8-bit organization. The data field is 16 or 8 bits to match the organization.

Top module: `fcg_top`

## Requirements
- R1: After reset, and while no frame has ended, `commit_o` and `abort_o` are both 0.
- R2: The write class (code 4) and write-all class (code 6) commit exactly when the counted clocks equal 3 + `addr_w_i` + 16 with `org16_i`=1, or 3 + `addr_w_i` + 1 + 8 with `org16_i`=0.
- R3: The erase class (code 5) and erase-all class (code 7) commit exactly when the counted clocks equal 3 + `addr_w_i` with `org16_i`=1, or 3 + `addr_w_i` + 1 with `org16_i`=0.
- R4: A programming frame whose count is larger or smaller than its expected length produces `abort_o` and no `commit_o`.
- R5: The idle (0), read (1), enable (2) and disable (3) classes produce neither `commit_o` nor `abort_o`, whatever the count.
- R6: The decision pulse appears in the cycle right after the first cycle in which `cs_i` is sampled low. It lasts one cycle, and each programming frame yields exactly one pulse.
- R7: The count saturates rather than wraps. A programming frame longer than its expected length by the counter's full range (64 extra clocks at default parameters) still aborts.
- R8: Counting begins at the start strobe. Clock strobes before the start bit, or while `cs_i` is low, are not counted, and a frame with no start strobe produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Synchronized chip select, high while a frame is in progress |
| sk_rise_i | input | 1 | One-cycle strobe per serial clock rising edge |
| start_i | input | 1 | One-cycle strobe on the serial clock rise that carries the start bit |
| class_i | input | 3 | Decoded instruction class: 0 idle, 1 read, 2 enable, 3 disable, 4 write, 5 erase, 6 write-all, 7 erase-all |
| org16_i | input | 1 | Organization: 1 selects 16-bit words, 0 selects 8-bit words |
| addr_w_i | input | 4 | Address field width for 16-bit organization |
| commit_o | output | 1 | One-cycle pulse: programming frame has the exact length |
| abort_o | output | 1 | One-cycle pulse: programming frame has the wrong length |

## Verification
The assertions assume that the class code, organization and address width stay steady from start bit to chip select fall. They also assume that `addr_w_i` never exceeds its parameterized maximum and that the strobes are single-cycle. The stimulus changes these inputs only while chip select is low. It separates strobes by idle cycles and keeps every address width inside the legal range, so each frame is judged on one well-defined expected length.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

  typedef enum logic [2:0] {
    CLS_IDLE  = 3'd0,
    CLS_READ  = 3'd1,
    CLS_WEN   = 3'd2,
    CLS_WDIS  = 3'd3,
    CLS_WRITE = 3'd4,
    CLS_ERASE = 3'd5,
    CLS_WALL  = 3'd6,
    CLS_EALL  = 3'd7
  } fcg_class_e;

  // Programming classes are the upper half of the code space.
  function automatic logic fcg_is_prog(input logic [2:0] cls);
    return cls[2];
  endfunction

  // Classes carrying a data field after the address.
  function automatic logic fcg_has_data(input logic [2:0] cls);
    return (cls == CLS_WRITE) || (cls == CLS_WALL);
  endfunction

endpackage

// File: rtl/fcg_rst_sync.sv
module fcg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/fcg_cs_edge.sv
module fcg_cs_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  output logic fall_o
);
  logic cs_q;
  logic cs_d;

  always_comb begin
    cs_d = cs_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b0;
    else         cs_q <= cs_d;
  end

  assign fall_o = cs_q & ~cs_i;
endmodule

// File: rtl/fcg_frame_len.sv
module fcg_frame_len
  import fcg_pkg::*;
#(
  parameter int unsigned AW_MAX   = 10,
  parameter int unsigned DATA_W16 = 16,
  parameter int unsigned DATA_W8  = 8,
  parameter int unsigned AWW      = $clog2(AW_MAX + 1),
  parameter int unsigned CNT_W    = 6
) (
  input  logic [2:0]       class_i,
  input  logic             org16_i,
  input  logic [AWW-1:0]   addr_w_i,
  output logic [CNT_W-1:0] len_o,
  output logic             prog_o
);
  localparam int unsigned HDR_BITS = 3;  // start bit plus two opcode bits

  logic [CNT_W-1:0] addr_part;
  logic [CNT_W-1:0] data_part;

  always_comb begin
    addr_part = CNT_W'(addr_w_i) + (org16_i ? CNT_W'(0) : CNT_W'(1));
    data_part = '0;
    if (fcg_has_data(class_i)) begin
      data_part = org16_i ? CNT_W'(DATA_W16) : CNT_W'(DATA_W8);
    end
    len_o  = CNT_W'(HDR_BITS) + addr_part + data_part;
    prog_o = fcg_is_prog(class_i);
  end
endmodule

// File: rtl/fcg_counter.sv
module fcg_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             sk_rise_i,
  input  logic             start_i,
  output logic [CNT_W-1:0] count_o,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] count_q, count_d;
  logic             armed_q, armed_d;
  logic             cnt_en;

  always_comb begin
    count_d = count_q;
    armed_d = armed_q;
    cnt_en  = 1'b0;
    if (!cs_i) begin
      count_d = '0;
      armed_d = 1'b0;
      cnt_en  = 1'b1;
    end else if (!armed_q && start_i) begin
      count_d = CNT_W'(1);
      armed_d = 1'b1;
      cnt_en  = 1'b1;
    end else if (armed_q && sk_rise_i) begin
      cnt_en = 1'b1;
      if (count_q != SAT) count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      count_q <= count_d;
      armed_q <= armed_d;
    end
  end

  assign count_o = count_q;
  assign armed_o = armed_q;

  assert_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && armed_q && sk_rise_i && count_q == SAT) |=> (count_q == SAT));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (count_q == '0 && !armed_q));

  assert_no_count_unarmed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !armed_q && !start_i) |=> (count_q == '0));
endmodule

// File: rtl/fcg_top.sv
module fcg_top
  import fcg_pkg::*;
#(
  parameter int unsigned AW_MAX   = 10,
  parameter int unsigned DATA_W16 = 16,
  parameter int unsigned DATA_W8  = 8,
  parameter int unsigned AWW      = $clog2(AW_MAX + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_i,
  input  logic           sk_rise_i,
  input  logic           start_i,
  input  logic [2:0]     class_i,
  input  logic           org16_i,
  input  logic [AWW-1:0] addr_w_i,
  output logic           commit_o,
  output logic           abort_o
);
  localparam int unsigned DATA_MAX = (DATA_W16 > DATA_W8) ? DATA_W16 : DATA_W8;
  localparam int unsigned LEN_MAX  = 3 + AW_MAX + 1 + DATA_MAX;
  // One spare bit keeps the saturation value above every legal length.
  localparam int unsigned CNT_W    = $clog2(LEN_MAX + 1) + 1;

  logic             rst_s_n;
  logic             cs_fall;
  logic [CNT_W-1:0] count;
  logic             armed;
  logic [CNT_W-1:0] exp_len;
  logic             is_prog;
  logic             commit_q, commit_d;
  logic             abort_q, abort_d;

  fcg_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s_n)
  );

  fcg_cs_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_s_n),
    .cs_i   (cs_i),
    .fall_o (cs_fall)
  );

  fcg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_s_n),
    .cs_i      (cs_i),
    .sk_rise_i (sk_rise_i),
    .start_i   (start_i),
    .count_o   (count),
    .armed_o   (armed)
  );

  fcg_frame_len #(
    .AW_MAX   (AW_MAX),
    .DATA_W16 (DATA_W16),
    .DATA_W8  (DATA_W8),
    .AWW      (AWW),
    .CNT_W    (CNT_W)
  ) u_len (
    .class_i  (class_i),
    .org16_i  (org16_i),
    .addr_w_i (addr_w_i),
    .len_o    (exp_len),
    .prog_o   (is_prog)
  );

  always_comb begin
    commit_d = 1'b0;
    abort_d  = 1'b0;
    if (cs_fall && armed && is_prog) begin
      commit_d = (count == exp_len);
      abort_d  = (count != exp_len);
    end
  end

  always_ff @(posedge clk_i or negedge rst_s_n) begin
    if (!rst_s_n) begin
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      commit_q <= commit_d;
      abort_q  <= abort_d;
    end
  end

  assign commit_o = commit_q;
  assign abort_o  = abort_q;

  assert_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({commit_o, abort_o}));

  assert_after_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || abort_o) |-> $past(!cs_i));

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || abort_o) |=> !(commit_o || abort_o));

  assert_prog_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || abort_o) |-> $past(fcg_is_prog(class_i)));

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_s_n |-> (!commit_o && !abort_o));
endmodule

// File: tb/fcg_top_tb_top.sv
module fcg_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic       skr = 1'b0;
  logic       st = 1'b0;
  logic [2:0] cls = 3'd0;
  logic       org = 1'b0;
  logic [3:0] aw = 4'd0;
  logic       commit, abort;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  fcg_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_rise_i(skr), .start_i(st),
    .class_i(cls), .org16_i(org), .addr_w_i(aw),
    .commit_o(commit), .abort_o(abort)
  );

  // Behavioural reference model: unbounded integer count.
  int  m_cnt = 0;
  bit  m_armed = 0;
  bit  m_prev = 0;
  bit  m_commit = 0;
  bit  m_abort = 0;

  function automatic int exp_len(input logic [2:0] c, input logic o, input logic [3:0] w);
    int l;
    l = 3 + int'(w) + (o ? 0 : 1);
    if (c == 3'd4 || c == 3'd6) l = l + (o ? 16 : 8);
    return l;
  endfunction

  always @(posedge clk) begin
    m_commit <= 0;
    m_abort  <= 0;
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_prev = 0;
    end else begin
      if (m_prev && !cs && m_armed && cls[2]) begin
        if (m_cnt == exp_len(cls, org, aw)) m_commit <= 1;
        else m_abort <= 1;
      end
      if (!cs) begin m_cnt = 0; m_armed = 0; end
      else if (!m_armed && st) begin m_cnt = 1; m_armed = 1; end
      else if (m_armed && skr) m_cnt = m_cnt + 1;
      m_prev = cs;
    end
  end

  int seen_c = 0;
  int seen_a = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (commit !== m_commit || abort !== m_abort) begin
        bad++;
        $display("FAIL %s model compare: actual c=%b a=%b expected c=%b a=%b",
                 cur_req, commit, abort, m_commit, m_abort);
      end
      if (commit === 1'b1) seen_c++;
      if (abort === 1'b1) seen_a++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input bit with_st);
    @(negedge clk); skr = 1; st = with_st;
    @(negedge clk); skr = 0; st = 0;
    @(negedge clk);
  endtask

  // One frame: lead clocks without start, then nclk clocks starting with start bit.
  task automatic frame(input string req, input logic [2:0] c, input logic o,
                       input logic [3:0] w, input int lead, input int nclk,
                       input bit has_start, input int ec, input int ea);
    int c0, a0;
    cur_req = req;
    @(negedge clk); cls = c; org = o; aw = w;
    pulse(0);                       // clock while cs low, never counted (R8)
    @(negedge clk); cs = 1;
    for (int i = 0; i < lead; i++) pulse(0);
    for (int i = 0; i < nclk; i++) pulse(has_start && i == 0);
    c0 = seen_c; a0 = seen_a;
    @(negedge clk); cs = 0;
    @(negedge clk);
    check("R6", {req, " commit one cycle after fall"}, int'(commit), ec);
    check("R6", {req, " abort one cycle after fall"}, int'(abort), ea);
    @(negedge clk);
    check("R6", {req, " pulse lasts one cycle"}, int'(commit | abort), 0);
    repeat (2) @(negedge clk);
    check(req, "commit pulses in frame", seen_c - c0, ec);
    check(req, "abort pulses in frame", seen_a - a0, ea);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", "commit after reset", int'(commit), 0);
    check("R1", "abort after reset", int'(abort), 0);

    // R2: write / write-all exact lengths
    frame("R2", 3'd4, 1'b0, 4'd6, 0, 18, 1, 1, 0);
    frame("R2", 3'd4, 1'b1, 4'd6, 0, 25, 1, 1, 0);
    frame("R2", 3'd6, 1'b1, 4'd8, 0, 27, 1, 1, 0);
    frame("R2", 3'd6, 1'b0, 4'd10, 0, 22, 1, 1, 0);
    // R3: erase / erase-all exact lengths
    frame("R3", 3'd5, 1'b0, 4'd7, 0, 11, 1, 1, 0);
    frame("R3", 3'd7, 1'b1, 4'd7, 0, 10, 1, 1, 0);
    // R4: extra and missing clocks
    frame("R4", 3'd4, 1'b0, 4'd6, 0, 19, 1, 0, 1);
    frame("R4", 3'd4, 1'b0, 4'd6, 0, 17, 1, 0, 1);
    frame("R4", 3'd5, 1'b0, 4'd7, 0, 10, 1, 0, 1);
    frame("R4", 3'd7, 1'b1, 4'd7, 0, 12, 1, 0, 1);
    // R5: non-programming classes never pulse
    frame("R5", 3'd1, 1'b1, 4'd6, 0, 25, 1, 0, 0);
    frame("R5", 3'd2, 1'b0, 4'd6, 0, 10, 1, 0, 0);
    frame("R5", 3'd3, 1'b1, 4'd6, 0, 5, 1, 0, 0);
    frame("R5", 3'd0, 1'b1, 4'd6, 0, 9, 1, 0, 0);
    // R7: length + 64 would alias on a wrapping 6-bit counter
    frame("R7", 3'd4, 1'b1, 4'd6, 0, 25 + 64, 1, 0, 1);
    // R8: leading clocks ignored, missing start bit yields nothing
    frame("R8", 3'd5, 1'b0, 4'd7, 3, 11, 1, 1, 0);
    frame("R8", 3'd4, 1'b0, 4'd6, 0, 18, 0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule